// File: doc/BRIEF.md
# Microcontroller Working Register File with Pointer Pairs

This block holds the thirty-two 8-bit working registers of a small 8-bit CPU core. Instruction operands use two combinational read ports and one clocked write port. When an instruction carries an immediate constant, the operand index is forced into the upper sixteen registers. A flag reports any attempt by such an instruction to name a register in the lower half.

The top six registers pair up into three 16-bit address pointers. Each pointer is read and written as one 16-bit word, so an address-generation unit can apply post-increment or pre-decrement updates in one cycle. A separate data-space port lets load/store logic reach every register by its data address. Register n sits at address n for n from 0x00 to 0x1F. A pointer holding such a small value therefore addresses the file itself.

Top module: `cpu_regfile`

## Requirements
- R1: A synchronous active-low reset clears all 32 registers to 0x00 at the next rising clock edge.
- R2: Both read ports return the addressed register combinationally. A read of a register written in the same cycle returns the old value until the edge, with no bypass.
- R3: An operand write (`op_we` high, `op_imm` low) stores `op_wr_data` into register `op_wr_idx` at the next rising edge, for every index 0..31.
- R4: With `op_imm` high, the write index and read port A index become 16 + bits [3:0] of the given index. `imm_illegal` is high combinationally when `op_imm` is high and either bit 4 of `rd_a_idx` is 0, or `op_we` is high and bit 4 of `op_wr_idx` is 0.
- R5: `ptr_rd_data` returns a pointer pair, high byte first: select 0 gives {R27,R26}, 1 gives {R29,R28}, 2 gives {R31,R30}, and 3 gives 0x0000.
- R6: A pointer write with select 0..2 loads both bytes of the pair on one edge, low byte into the even register. The result is visible in the next cycle. Select 3 changes nothing.
- R7: A data-space access with `ds_en` high and `ds_addr` below 0x0020 raises `ds_hit` and reads or writes register `ds_addr`. At 0x0020 and above, `ds_hit` and `ds_rdata` are 0 and a write leaves the file unchanged.
- R8: When writes meet on one register in one cycle, the pointer write beats the operand write, and the operand write beats the data-space write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| op_imm | input | 1 | Current instruction uses the immediate form |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 8 | Read port A data |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 8 | Read port B data |
| op_we | input | 1 | Operand write enable |
| op_wr_idx | input | 5 | Operand write register index |
| op_wr_data | input | 8 | Operand write data |
| imm_illegal | output | 1 | Immediate-form index names a lower-half register |
| ptr_rd_sel | input | 2 | Pointer read select (0, 1, 2; 3 = none) |
| ptr_rd_data | output | 16 | Selected pointer value |
| ptr_we | input | 1 | Pointer write enable |
| ptr_wr_sel | input | 2 | Pointer write select (0, 1, 2; 3 = none) |
| ptr_wr_data | input | 16 | Pointer write value |
| ds_en | input | 1 | Data-space access strobe |
| ds_we | input | 1 | Data-space access is a write |
| ds_addr | input | 16 | Data-space address |
| ds_wdata | input | 8 | Data-space write data |
| ds_rdata | output | 8 | Data-space read data |
| ds_hit | output | 1 | Address falls inside the register window |

## Verification
Each register's state is stored in one place only, and all three read paths show it combinationally. A corrupted byte or a misdirected write therefore shows up in the cycle right after the faulty edge, on whichever port addresses that register. A wrong pointer-pair wiring shows up as swapped or misplaced bytes: `ptr_rd_data` and the single-register reads of R26..R31 disagree. A wrong priority between writers appears only on the collided register, one cycle after the collision, so each collision pair is driven deliberately.

// File: rtl/rf_pkg.sv
// Shared constants and types for the working register file.
// Assumes: register count is a power of two and at least eight.
package rf_pkg;
    parameter int RF_REGS = 32;
    parameter int RF_DW   = 8;

    // Pointer pair selector; the code value equals the pair's position above the base.
    typedef enum logic [1:0] {
        PTR_X    = 2'd0,
        PTR_Y    = 2'd1,
        PTR_Z    = 2'd2,
        PTR_NONE = 2'd3
    } ptr_sel_e;
endpackage

// File: rtl/rf_index_map.sv
// Maps operand indices for immediate-form instructions onto the upper half
// of the file and flags indices that name the lower half.
// Assumes: AW >= 2; the upper half is the set of indices with the top bit set.
module rf_index_map #(
    parameter int AW = 5
) (
    input  logic          op_imm,
    input  logic          op_we,
    input  logic [AW-1:0] rd_a_idx,
    input  logic [AW-1:0] op_wr_idx,
    output logic [AW-1:0] eff_rd_a,
    output logic [AW-1:0] eff_wr,
    output logic          imm_illegal
);
    // Force the top index bit when the immediate form is in use.
    always_comb begin
        if (op_imm) begin
            eff_rd_a = {1'b1, rd_a_idx[AW-2:0]};
            eff_wr   = {1'b1, op_wr_idx[AW-2:0]};
        end else begin
            eff_rd_a = rd_a_idx;
            eff_wr   = op_wr_idx;
        end
    end

    // Raise the flag when an immediate-form operand points below the upper half.
    always_comb begin
        imm_illegal = op_imm && (!rd_a_idx[AW-1] || (op_we && !op_wr_idx[AW-1]));
    end
endmodule

// File: rtl/rf_write_arbiter.sv
// Per-register write arbitration among the pointer, operand and data-space
// writers. Priority: pointer first, operand second, data space last.
// Assumes: the top six registers form three pointer pairs, even index = low byte.
module rf_write_arbiter #(
    parameter int NREG = 32,
    parameter int DW   = 8,
    parameter int AW   = $clog2(NREG)
) (
    input  logic                      op_we,
    input  logic [AW-1:0]             op_idx,
    input  logic [DW-1:0]             op_data,
    input  logic                      ptr_we,
    input  logic [1:0]                ptr_sel,
    input  logic [2*DW-1:0]           ptr_data,
    input  logic                      ds_we,
    input  logic [AW-1:0]             ds_idx,
    input  logic [DW-1:0]             ds_data,
    output logic [NREG-1:0]           wen,
    output logic [NREG-1:0][DW-1:0]   wdat
);
    localparam int PTR_BASE = NREG - 6;

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        localparam bit IS_PTR = (g >= PTR_BASE);
        localparam int PAIR   = IS_PTR ? (g - PTR_BASE) / 2 : 0;
        localparam bit IS_HI  = IS_PTR && (((g - PTR_BASE) % 2) == 1);

        logic ptr_hit;
        logic op_hit;
        logic ds_hit;

        // Decode which writers target this register in the current cycle.
        always_comb begin
            ptr_hit = IS_PTR && ptr_we && (ptr_sel == 2'(PAIR));
            op_hit  = op_we && (op_idx == AW'(g));
            ds_hit  = ds_we && (ds_idx == AW'(g));
        end

        // Pick the winning writer's byte for this register.
        always_comb begin
            wen[g]  = ptr_hit || op_hit || ds_hit;
            if (ptr_hit) begin
                wdat[g] = IS_HI ? ptr_data[2*DW-1:DW] : ptr_data[DW-1:0];
            end else if (op_hit) begin
                wdat[g] = op_data;
            end else begin
                wdat[g] = ds_data;
            end
        end
    end
endmodule

// File: rtl/rf_storage.sv
// Register array with per-register write enables and synchronous active-low clear.
// Assumes: at most one data value per register per cycle (arbitrated upstream).
module rf_storage #(
    parameter int NREG = 32,
    parameter int DW   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NREG-1:0]         wen,
    input  logic [NREG-1:0][DW-1:0] wdat,
    output logic [NREG-1:0][DW-1:0] q
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Hold one register: clear on reset, load when enabled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[g] <= '0;
            end else if (wen[g]) begin
                q[g] <= wdat[g];
            end
        end
    end
endmodule

// File: rtl/cpu_regfile.sv
// Working register file: two operand read ports, one operand write port,
// 16-bit pointer pair access to the top six registers, and a data-space
// window mapping register n to address n.
// Assumes: reads are combinational without write bypass; reset is synchronous.
module cpu_regfile #(
    parameter int NREG = rf_pkg::RF_REGS,
    parameter int DW   = rf_pkg::RF_DW,
    parameter int AW   = $clog2(NREG),
    parameter int PW   = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_imm,
    input  logic [AW-1:0] rd_a_idx,
    output logic [DW-1:0] rd_a_data,
    input  logic [AW-1:0] rd_b_idx,
    output logic [DW-1:0] rd_b_data,
    input  logic          op_we,
    input  logic [AW-1:0] op_wr_idx,
    input  logic [DW-1:0] op_wr_data,
    output logic          imm_illegal,
    input  logic [1:0]    ptr_rd_sel,
    output logic [PW-1:0] ptr_rd_data,
    input  logic          ptr_we,
    input  logic [1:0]    ptr_wr_sel,
    input  logic [PW-1:0] ptr_wr_data,
    input  logic          ds_en,
    input  logic          ds_we,
    input  logic [PW-1:0] ds_addr,
    input  logic [DW-1:0] ds_wdata,
    output logic [DW-1:0] ds_rdata,
    output logic          ds_hit
);
    import rf_pkg::*;

    localparam int            PTR_BASE = NREG - 6;
    localparam logic [PW-1:0] DS_LIMIT = PW'(NREG);

    logic [AW-1:0]             eff_rd_a;
    logic [AW-1:0]             eff_wr;
    logic [NREG-1:0]           wen;
    logic [NREG-1:0][DW-1:0]   wdat;
    logic [NREG-1:0][DW-1:0]   rf_q;
    logic [AW-1:0]             ds_idx;
    ptr_sel_e                  rd_sel;

    rf_index_map #(.AW(AW)) u_map (
        .op_imm      (op_imm),
        .op_we       (op_we),
        .rd_a_idx    (rd_a_idx),
        .op_wr_idx   (op_wr_idx),
        .eff_rd_a    (eff_rd_a),
        .eff_wr      (eff_wr),
        .imm_illegal (imm_illegal)
    );

    // Decode the data-space window and the register it lands on.
    always_comb begin
        ds_hit = ds_en && (ds_addr < DS_LIMIT);
        ds_idx = ds_addr[AW-1:0];
    end

    rf_write_arbiter #(.NREG(NREG), .DW(DW), .AW(AW)) u_arb (
        .op_we    (op_we),
        .op_idx   (eff_wr),
        .op_data  (op_wr_data),
        .ptr_we   (ptr_we),
        .ptr_sel  (ptr_wr_sel),
        .ptr_data (ptr_wr_data),
        .ds_we    (ds_we && ds_hit),
        .ds_idx   (ds_idx),
        .ds_data  (ds_wdata),
        .wen      (wen),
        .wdat     (wdat)
    );

    rf_storage #(.NREG(NREG), .DW(DW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wen   (wen),
        .wdat  (wdat),
        .q     (rf_q)
    );

    // Operand read ports: plain muxes over current register contents.
    always_comb begin
        rd_a_data = rf_q[eff_rd_a];
        rd_b_data = rf_q[rd_b_idx];
    end

    // Data-space read: register contents inside the window, zero outside.
    always_comb begin
        ds_rdata = ds_hit ? rf_q[ds_idx] : '0;
    end

    // Pointer read: assemble the selected pair, high byte on top.
    always_comb begin
        rd_sel = ptr_sel_e'(ptr_rd_sel);
        case (rd_sel)
            PTR_X:   ptr_rd_data = {rf_q[PTR_BASE+1], rf_q[PTR_BASE]};
            PTR_Y:   ptr_rd_data = {rf_q[PTR_BASE+3], rf_q[PTR_BASE+2]};
            PTR_Z:   ptr_rd_data = {rf_q[PTR_BASE+5], rf_q[PTR_BASE+4]};
            default: ptr_rd_data = '0;
        endcase
    end
endmodule

// File: rtl/rf_checker.sv
// Property checker for the register file, attached by bind.
// Assumes: it sees the register contents through the flattened storage vector.
module rf_checker #(
    parameter int NREG = 32,
    parameter int DW   = 8,
    parameter int AW   = 5,
    parameter int PW   = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 op_we,
    input logic                 op_imm,
    input logic [AW-1:0]        op_wr_idx,
    input logic [DW-1:0]        op_wr_data,
    input logic                 ptr_we,
    input logic [1:0]           ptr_wr_sel,
    input logic [PW-1:0]        ptr_wr_data,
    input logic                 ds_en,
    input logic                 ds_we,
    input logic [PW-1:0]        ds_addr,
    input logic                 ds_hit,
    input logic [DW-1:0]        ds_rdata,
    input logic [NREG*DW-1:0]   rf_q
);
    localparam int            PTR_BASE = NREG - 6;
    localparam logic [PW-1:0] DS_LIMIT = PW'(NREG);

    logic [AW-1:0] tgt_idx;
    logic          ptr_clash;
    logic [AW-1:0] prev_tgt;
    logic [1:0]    prev_sel;
    logic [DW-1:0] slot_op;
    logic [PW-1:0] slot_pair;

    // Register the operand targets of a pointer write addresses, per spec.
    always_comb begin
        tgt_idx   = op_imm ? {1'b1, op_wr_idx[AW-2:0]} : op_wr_idx;
        ptr_clash = ptr_we && (ptr_wr_sel != 2'd3) && (int'(tgt_idx) >= PTR_BASE)
                    && (((int'(tgt_idx) - PTR_BASE) / 2) == int'(ptr_wr_sel));
    end

    // Remember last cycle's targets so the slot can be looked up after the edge.
    always_ff @(posedge clk) begin
        prev_tgt <= tgt_idx;
        prev_sel <= ptr_wr_sel;
    end

    // Fetch the bytes that last cycle's writes should have reached.
    always_comb begin
        slot_op   = rf_q[int'(prev_tgt)*DW +: DW];
        slot_pair = rf_q[(PTR_BASE + 2*int'(prev_sel))*DW +: PW];
    end

    a_r3_op_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (op_we && !op_imm && !ptr_clash) |=> (slot_op == $past(op_wr_data)));

    a_r4_imm_upper_half: assert property (@(posedge clk) disable iff (!rst_n)
        (op_we && op_imm && !ptr_clash) |=> (slot_op == $past(op_wr_data)));

    a_r6_ptr_pair_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_we && ptr_wr_sel != 2'd3) |=> (slot_pair == $past(ptr_wr_data)));

    a_r6_ptr_none_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_we && ptr_wr_sel == 2'd3 && !op_we && !(ds_en && ds_we)) |=> $stable(rf_q));

    a_r7_ds_outside_window: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_en && ds_addr >= DS_LIMIT) |-> (!ds_hit && ds_rdata == '0));

    a_r7_ds_far_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_en && ds_we && ds_addr >= DS_LIMIT && !op_we && !ptr_we) |=> $stable(rf_q));
endmodule

bind cpu_regfile rf_checker #(.NREG(NREG), .DW(DW), .AW(AW), .PW(PW)) u_rf_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_we       (op_we),
    .op_imm      (op_imm),
    .op_wr_idx   (op_wr_idx),
    .op_wr_data  (op_wr_data),
    .ptr_we      (ptr_we),
    .ptr_wr_sel  (ptr_wr_sel),
    .ptr_wr_data (ptr_wr_data),
    .ds_en       (ds_en),
    .ds_we       (ds_we),
    .ds_addr     (ds_addr),
    .ds_hit      (ds_hit),
    .ds_rdata    (ds_rdata),
    .rf_q        (rf_q)
);

// File: tb/tb_cpu_regfile.sv
// Directed bench: one task per scenario; inputs change on the falling edge,
// outputs are sampled 1 ns later, well before the next rising edge.
module tb_cpu_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_imm = 1'b0;
    logic [4:0]  rd_a_idx = '0;
    logic [7:0]  rd_a_data;
    logic [4:0]  rd_b_idx = '0;
    logic [7:0]  rd_b_data;
    logic        op_we = 1'b0;
    logic [4:0]  op_wr_idx = '0;
    logic [7:0]  op_wr_data = '0;
    logic        imm_illegal;
    logic [1:0]  ptr_rd_sel = '0;
    logic [15:0] ptr_rd_data;
    logic        ptr_we = 1'b0;
    logic [1:0]  ptr_wr_sel = '0;
    logic [15:0] ptr_wr_data = '0;
    logic        ds_en = 1'b0;
    logic        ds_we = 1'b0;
    logic [15:0] ds_addr = '0;
    logic [7:0]  ds_wdata = '0;
    logic [7:0]  ds_rdata;
    logic        ds_hit;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] mdl [32];

    always #5 clk = ~clk;

    cpu_regfile dut (.*);

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic quiet();
        op_we = 0; op_imm = 0; ptr_we = 0; ds_en = 0; ds_we = 0;
    endtask

    task automatic read_b(input int idx, output logic [7:0] v);
        rd_b_idx = 5'(idx); #1; v = rd_b_data;
    endtask

    task automatic t_reset_state();
        logic [7:0] v;
        for (int r = 0; r < 32; r++) begin
            rd_a_idx = 5'(r); rd_b_idx = 5'(31 - r); #1;
            chk("R1 reset port A", 16'(rd_a_data), 16'h0);
            chk("R1 reset port B", 16'(rd_b_data), 16'h0);
        end
        @(negedge clk); op_we = 1; op_wr_idx = 5'd7; op_wr_data = 8'h5A;
        @(negedge clk); quiet(); rst_n = 0;
        @(negedge clk); rst_n = 1;
        read_b(7, v); chk("R1 reset clears written reg", 16'(v), 16'h0);
        for (int r = 0; r < 32; r++) mdl[r] = 8'h00;
    endtask

    task automatic t_operand_rw();
        for (int r = 0; r < 32; r++) begin
            @(negedge clk); op_we = 1; op_wr_idx = 5'(r); op_wr_data = 8'(r*37 + 11);
            mdl[r] = 8'(r*37 + 11);
        end
        @(negedge clk); quiet();
        for (int r = 0; r < 32; r++) begin
            rd_a_idx = 5'(r); rd_b_idx = 5'(31 - r); #1;
            chk("R3 operand write via port A", 16'(rd_a_data), 16'(mdl[r]));
            chk("R2 read port B", 16'(rd_b_data), 16'(mdl[31 - r]));
        end
    endtask

    task automatic t_no_bypass();
        @(negedge clk); op_we = 1; op_wr_idx = 5'd9; op_wr_data = 8'hC3;
        rd_a_idx = 5'd9; rd_b_idx = 5'd9; #1;
        chk("R2 no bypass port A", 16'(rd_a_data), 16'(mdl[9]));
        chk("R2 no bypass port B", 16'(rd_b_data), 16'(mdl[9]));
        @(negedge clk); quiet(); mdl[9] = 8'hC3; #1;
        chk("R2 new value after edge", 16'(rd_a_data), 16'hC3);
    endtask

    task automatic t_immediate();
        logic [7:0] v;
        @(negedge clk); op_imm = 1; op_we = 1; op_wr_idx = 5'h05; op_wr_data = 8'hA7;
        rd_a_idx = 5'h13; #1;
        chk("R4 illegal on low write idx", 16'(imm_illegal), 16'h1);
        chk("R4 imm read lands on R19", 16'(rd_a_data), 16'(mdl[19]));
        @(negedge clk); quiet(); mdl[21] = 8'hA7;
        read_b(21, v); chk("R4 imm write lands on R21", 16'(v), 16'hA7);
        read_b(5, v);  chk("R4 R5 untouched", 16'(v), 16'(mdl[5]));
        op_imm = 1; op_we = 1; op_wr_idx = 5'h12; op_wr_data = 8'h3C; rd_a_idx = 5'h14; #1;
        chk("R4 legal upper idx no flag", 16'(imm_illegal), 16'h0);
        @(negedge clk); quiet(); mdl[18] = 8'h3C;
        read_b(18, v); chk("R4 upper write R18", 16'(v), 16'h3C);
        op_imm = 1; rd_a_idx = 5'h02; #1;
        chk("R4 illegal on low read idx", 16'(imm_illegal), 16'h1);
        op_imm = 0; #1;
        chk("R4 no flag without imm", 16'(imm_illegal), 16'h0);
    endtask

    task automatic ptr_write(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk); ptr_we = 1; ptr_wr_sel = sel; ptr_wr_data = val;
        @(negedge clk); quiet();
        if (sel != 2'd3) begin
            mdl[26 + 2*sel] = val[7:0]; mdl[27 + 2*sel] = val[15:8];
        end
    endtask

    task automatic t_pointer();
        logic [7:0] v;
        ptr_write(2'd0, 16'h1234);
        ptr_write(2'd1, 16'hBEEF);
        ptr_write(2'd2, 16'h0013);
        for (int p = 0; p < 3; p++) begin
            ptr_rd_sel = 2'(p); #1;
            chk("R5 pointer read", ptr_rd_data, {mdl[27 + 2*p], mdl[26 + 2*p]});
        end
        read_b(26, v); chk("R6 X low byte in R26", 16'(v), 16'h34);
        read_b(27, v); chk("R6 X high byte in R27", 16'(v), 16'h12);
        read_b(29, v); chk("R6 Y high byte in R29", 16'(v), 16'hBE);
        ptr_write(2'd3, 16'hFFFF);
        for (int r = 26; r < 32; r++) begin
            read_b(r, v); chk("R6 select 3 write ignored", 16'(v), 16'(mdl[r]));
        end
        ptr_rd_sel = 2'd3; #1;
        chk("R5 select 3 reads zero", ptr_rd_data, 16'h0);
    endtask

    task automatic t_dspace();
        logic [7:0] v;
        @(negedge clk); ds_en = 1; ds_we = 1; ds_addr = 16'h0005; ds_wdata = 8'h6E; #1;
        chk("R7 hit inside window", 16'(ds_hit), 16'h1);
        @(negedge clk); quiet(); mdl[5] = 8'h6E;
        read_b(5, v); chk("R7 data-space write R5", 16'(v), 16'h6E);
        ds_en = 1; ds_addr = 16'h001F; #1;
        chk("R7 data-space read R31", 16'(ds_rdata), 16'(mdl[31]));
        ptr_rd_sel = 2'd2; #1; ds_addr = ptr_rd_data; #1;
        chk("R7 pointer addresses the file", 16'(ds_rdata), 16'(mdl[19]));
        @(negedge clk); ds_en = 1; ds_we = 1; ds_addr = 16'h0020; ds_wdata = 8'h99; #1;
        chk("R7 no hit at 0x20", 16'(ds_hit), 16'h0);
        chk("R7 read zero at 0x20", 16'(ds_rdata), 16'h0);
        @(negedge clk); ds_addr = 16'h0105;
        @(negedge clk); quiet();
        read_b(0, v); chk("R7 write at 0x20 ignored", 16'(v), 16'(mdl[0]));
        read_b(5, v); chk("R7 write at 0x105 ignored", 16'(v), 16'(mdl[5]));
    endtask

    task automatic t_priority();
        logic [7:0] v;
        @(negedge clk); ptr_we = 1; ptr_wr_sel = 2'd2; ptr_wr_data = 16'h4455;
        op_we = 1; op_wr_idx = 5'd30; op_wr_data = 8'h11;
        @(negedge clk); quiet();
        read_b(30, v); chk("R8 pointer beats operand", 16'(v), 16'h55);
        read_b(31, v); chk("R8 pointer high byte", 16'(v), 16'h44);
        op_we = 1; op_wr_idx = 5'd3; op_wr_data = 8'h21;
        ds_en = 1; ds_we = 1; ds_addr = 16'h0003; ds_wdata = 8'h84;
        @(negedge clk); quiet();
        read_b(3, v); chk("R8 operand beats data space", 16'(v), 16'h21);
        ptr_we = 1; ptr_wr_sel = 2'd0; ptr_wr_data = 16'h7788;
        ds_en = 1; ds_we = 1; ds_addr = 16'h001B; ds_wdata = 8'h01;
        @(negedge clk); quiet();
        read_b(27, v); chk("R8 pointer beats data space", 16'(v), 16'h77);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset_state();
        t_operand_rw();
        t_no_bypass();
        t_immediate();
        t_pointer();
        t_dspace();
        t_priority();
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end
endmodule